// File: doc/BRIEF.md
# Frequency Synthesizer Control Register with Lock Countdown

This block is the single control word for a frequency-synthesis unit. It is written and read back over a plain register bus. It keeps the multiplier, output-range, lock-count, pre-divider and secondary post-divider fields, and turns them into ready-decoded controls for the downstream clock path. A behavioural stand-in reports the multiply ratio that the configuration asks for.

Every write starts a lock countdown. The write pulse crosses into a separate slow clock domain as a toggle. The slow side counts the programmed number of slow-clock cycles and raises a lock flag. That flag returns to the bus domain through a two-flop synchronizer, together with an acknowledge toggle. The acknowledge lets the bus side ignore a flag that belongs to an earlier write. The bus-side lock output drops in the same cycle that a write is accepted. It is held low whenever the multiplier or the pre-divider code is zero.

For use, successive writes must be spaced by at least three slow-clock periods, so that the slow side sees every toggle.

Top module: `pll_ctl_reg`

## Requirements
- R1: A write stores wdata, and from the next cycle rdata returns it with the unused bits cleared. The fields are pre-divider 7:0, lock count 13:8, output range 15:14, multiplier 26:16 and post-divider select 29:28. The range field appears unchanged on out_range.
- R2: A multiplier field of 0 gives pll_active=0 and synth_mult=0. A value m from 1 to 2047 gives pll_active=1 and synth_mult=m+1.
- R3: Pre-divider code 0 gives div_hold=1 and div_bypass=0. Code 1 gives div_bypass=1 and div_hold=0. Codes 2 to 255 clear both flags. div_ratio always equals the code.
- R4: Post-divider select 00, 01 and 10 give usb_shift 0, 1 and 2, meaning divide by 1, 2 and 4. The reserved code 11 gives usb_shift 2, while rdata still returns 11.
- R5: lock reads 0 in the cycle after any accepted write.
- R6: Counting the first slow edge after the write edge as edge 1, the slow side arms at edge 3 and sets its flag at edge 4+N, where N is the lock count. lock rises after two further bus edges. The bus-side model tracks this on every cycle.
- R7: A lock count of 0 sets the slow flag at slow edge 4, the first slow edge after arming.
- R8: lock stays 0 while the multiplier field or the pre-divider code is 0, even after the countdown expires.
- R9: During reset, rdata is 0, lock is 0 and pll_active is 0.
- R10: Bits 31:30 and 27 always read 0, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Slow clock for the lock countdown |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Stored register value |
| lock | output | 1 | Lock status, bus domain |
| pll_active | output | 1 | Multiplier non-zero |
| mul_code | output | 11 | Multiplier field |
| out_range | output | 2 | Output frequency range field |
| div_ratio | output | 8 | Pre-divider code |
| div_hold | output | 1 | Pre-divider output forced low |
| div_bypass | output | 1 | Pre-divider bypassed |
| usb_shift | output | 2 | Post-divider as a power of two |
| synth_mult | output | 12 | Multiply ratio reported by the stand-in |

## Verification
A wrong field slice or a wrong mask shows up on rdata and on the decoded outputs in the first cycle after the write. A stale lock flag or acknowledge in either domain shows up as lock high right after a write, or as lock rising a whole slow period early or late. An off-by-one in the countdown moves the rising edge of lock by ten bus cycles, and the cycle-accurate model exposes that within one countdown.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
   localparam int REG_W   = 32;
   localparam int DIV_LSB = 0;
   localparam int DIV_W   = 8;
   localparam int CNT_LSB = 8;
   localparam int CNT_W   = 6;
   localparam int RNG_LSB = 14;
   localparam int RNG_W   = 2;
   localparam int MUL_LSB = 16;
   localparam int MUL_W   = 11;
   localparam int USB_LSB = 28;
   localparam int USB_W   = 2;

   typedef enum logic [USB_W-1:0] {
      USB_BY1  = 2'b00,
      USB_BY2  = 2'b01,
      USB_BY4  = 2'b10,
      USB_RSVD = 2'b11
   } usb_sel_e;

   typedef struct packed {
      logic [USB_W-1:0] usb;
      logic [MUL_W-1:0] mul;
      logic [RNG_W-1:0] rng;
      logic [CNT_W-1:0] cnt;
      logic [DIV_W-1:0] div;
   } pll_cfg_t;

   function automatic logic [REG_W-1:0] span(input int lsb, input int w);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < REG_W; i++)
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] live_mask();
      return span(DIV_LSB, DIV_W) | span(CNT_LSB, CNT_W) | span(RNG_LSB, RNG_W)
           | span(MUL_LSB, MUL_W) | span(USB_LSB, USB_W);
   endfunction

   function automatic pll_cfg_t unpack_word(input logic [REG_W-1:0] w);
      pll_cfg_t c;
      c.div = w[DIV_LSB +: DIV_W];
      c.cnt = w[CNT_LSB +: CNT_W];
      c.rng = w[RNG_LSB +: RNG_W];
      c.mul = w[MUL_LSB +: MUL_W];
      c.usb = w[USB_LSB +: USB_W];
      return c;
   endfunction

   function automatic logic [REG_W-1:0] pack_word(input pll_cfg_t c);
      logic [REG_W-1:0] w;
      w = '0;
      w[DIV_LSB +: DIV_W] = c.div;
      w[CNT_LSB +: CNT_W] = c.cnt;
      w[RNG_LSB +: RNG_W] = c.rng;
      w[MUL_LSB +: MUL_W] = c.mul;
      w[USB_LSB +: USB_W] = c.usb;
      return w;
   endfunction
endpackage

// File: rtl/pll_sync_bits.sv
module pll_sync_bits #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("pll_sync_bits: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pll_sync_bits: W must be at least 1");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
   import pll_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output pll_cfg_t         cfg,
   output logic [REG_W-1:0] rdata,
   output logic             wr_tog
);
   pll_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         wr_tog <= 1'b0;
      end else if (wr_en) begin
         cfg_q  <= unpack_word(wdata);
         wr_tog <= ~wr_tog;
      end
   end

   assign cfg   = cfg_q;
   assign rdata = pack_word(cfg_q);
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int SYNC_STAGES = 2,
   parameter int CW          = 6
) (
   input  logic          slow_clk,
   input  logic          rst_n,
   input  logic          wr_tog,
   input  logic [CW-1:0] cnt_val,
   output logic          lock_slow,
   output logic          ack_tog
);
   logic          tog_s;
   logic          tog_d;
   logic          run;
   logic          arm;
   logic [CW-1:0] cnt;

   pll_sync_bits #(.W(1), .STAGES(SYNC_STAGES)) u_tog_sync (
      .clk   (slow_clk),
      .rst_n (rst_n),
      .d     (wr_tog),
      .q     (tog_s)
   );

   assign arm = tog_s ^ tog_d;

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_d     <= 1'b0;
         ack_tog   <= 1'b0;
         run       <= 1'b0;
         cnt       <= '0;
         lock_slow <= 1'b0;
      end else begin
         tog_d   <= tog_s;
         ack_tog <= tog_d;
         if (arm) begin
            cnt       <= cnt_val;
            run       <= 1'b1;
            lock_slow <= 1'b0;
         end else if (run) begin
            if (cnt == '0) begin
               lock_slow <= 1'b1;
               run       <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pll_ratio_model.sv
module pll_ratio_model
   import pll_ctl_pkg::*;
#(
   parameter bit RSVD_AS_DIV4 = 1'b1
) (
   input  pll_cfg_t         cfg,
   output logic             pll_active,
   output logic [MUL_W:0]   synth_mult,
   output logic             div_hold,
   output logic             div_bypass,
   output logic [DIV_W-1:0] div_ratio,
   output logic [1:0]       usb_shift
);
   logic [1:0] rsvd_shift;

   if (RSVD_AS_DIV4) begin : g_rsvd_div4
      assign rsvd_shift = 2'd2;
   end else begin : g_rsvd_div1
      assign rsvd_shift = 2'd0;
   end

   assign pll_active = |cfg.mul;
   assign synth_mult = pll_active ? ({1'b0, cfg.mul} + 1'b1) : '0;
   assign div_hold   = (cfg.div == '0);
   assign div_bypass = (cfg.div == DIV_W'(1));
   assign div_ratio  = cfg.div;

   always_comb begin
      case (usb_sel_e'(cfg.usb))
         USB_BY1: usb_shift = 2'd0;
         USB_BY2: usb_shift = 2'd1;
         USB_BY4: usb_shift = 2'd2;
         default: usb_shift = rsvd_shift;
      endcase
   end
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
   import pll_ctl_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit RSVD_AS_DIV4 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_clk,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             lock,
   output logic             pll_active,
   output logic [MUL_W-1:0] mul_code,
   output logic [RNG_W-1:0] out_range,
   output logic [DIV_W-1:0] div_ratio,
   output logic             div_hold,
   output logic             div_bypass,
   output logic [1:0]       usb_shift,
   output logic [MUL_W:0]   synth_mult
);
   localparam int TOP_BIT = USB_LSB + USB_W;

   if (TOP_BIT > REG_W) begin : g_bad_layout
      $error("pll_ctl_reg: field layout exceeds register width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pll_ctl_reg: SYNC_STAGES must be at least 2");
   end

   pll_cfg_t   cfg;
   logic       wr_tog;
   logic       lock_slow;
   logic       ack_tog;
   logic [1:0] back_q;
   logic       lock_b;
   logic       ack_b;

   pll_cfg_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wdata  (wdata),
      .cfg    (cfg),
      .rdata  (rdata),
      .wr_tog (wr_tog)
   );

   pll_lock_timer #(.SYNC_STAGES(SYNC_STAGES), .CW(CNT_W)) u_timer (
      .slow_clk  (slow_clk),
      .rst_n     (rst_n),
      .wr_tog    (wr_tog),
      .cnt_val   (cfg.cnt),
      .lock_slow (lock_slow),
      .ack_tog   (ack_tog)
   );

   pll_sync_bits #(.W(2), .STAGES(SYNC_STAGES)) u_back_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({lock_slow, ack_tog}),
      .q     (back_q)
   );

   assign lock_b = back_q[1];
   assign ack_b  = back_q[0];

   pll_ratio_model #(.RSVD_AS_DIV4(RSVD_AS_DIV4)) u_ratio (
      .cfg        (cfg),
      .pll_active (pll_active),
      .synth_mult (synth_mult),
      .div_hold   (div_hold),
      .div_bypass (div_bypass),
      .div_ratio  (div_ratio),
      .usb_shift  (usb_shift)
   );

   assign mul_code  = cfg.mul;
   assign out_range = cfg.rng;
   assign lock      = lock_b & (ack_b == wr_tog) & pll_active & ~div_hold;
endmodule

// File: rtl/pll_ctl_chk.sv
module pll_ctl_chk
   import pll_ctl_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wdata,
   input logic [REG_W-1:0] rdata,
   input logic             lock,
   input logic             pll_active,
   input logic             div_hold,
   input logic             div_bypass,
   input logic [1:0]       usb_shift,
   input logic [MUL_W:0]   synth_mult
);
   localparam logic [REG_W-1:0] MASK = live_mask();

   assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rdata == ($past(wdata) & MASK)));

   assert_mul_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[MUL_LSB +: MUL_W] == '0) |-> (synth_mult == '0 && !pll_active));

   assert_div_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({div_hold, div_bypass}));

   assert_usb_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      usb_shift != 2'd3);

   assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !lock);

   assert_rise_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> !$past(wr_en));

   assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[MUL_LSB +: MUL_W] == '0 || rdata[DIV_LSB +: DIV_W] == '0) |-> !lock);

   assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~MASK) == '0);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R9: assert (rdata == '0 && !lock && !pll_active);
      end
   end
endmodule

bind pll_ctl_reg pll_ctl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wdata      (wdata),
   .rdata      (rdata),
   .lock       (lock),
   .pll_active (pll_active),
   .div_hold   (div_hold),
   .div_bypass (div_bypass),
   .usb_shift  (usb_shift),
   .synth_mult (synth_mult)
);

// File: tb/sim_pll_ctl_reg.sv
module sim_pll_ctl_reg;
   logic        clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        lock, pll_active, div_hold, div_bypass;
   logic [10:0] mul_code;
   logic [1:0]  out_range, usb_shift;
   logic [7:0]  div_ratio;
   logic [11:0] synth_mult;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   initial begin
      #1;
      forever #20 slow_clk = ~slow_clk;
   end

   pll_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .lock(lock), .pll_active(pll_active), .mul_code(mul_code),
      .out_range(out_range), .div_ratio(div_ratio), .div_hold(div_hold),
      .div_bypass(div_bypass), .usb_shift(usb_shift), .synth_mult(synth_mult)
   );

   // behavioural reference
   logic [31:0] m_reg = '0;
   int m_seq = 0, m_seen = 0, m_ack = 0, m_since = 100000, m_n = 0;
   bit m_pend = 0, m_ls = 0;
   bit d1_l = 0, d2_l = 0;
   int d1_a = 0, d2_a = 0;

   always @(posedge slow_clk) begin
      if (rst_n) begin
         if (m_pend) begin
            m_pend = 0; m_since = 1; m_seen = m_seq;
         end else if (m_since < 100000) m_since++;
         if (m_since == 3) begin m_ls = 0; m_n = int'(m_reg[13:8]); end
         if (m_since == 4) m_ack = m_seen;
         if (m_since == 4 + m_n) m_ls = 1;
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         d2_l = d1_l; d1_l = m_ls;
         d2_a = d1_a; d1_a = m_ack;
         if (wr_en) begin
            m_seq++;
            m_reg = wdata & 32'h37FF_FFFF;
            m_pend = 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [10:0] m_mul;
         logic [7:0]  m_div;
         logic [1:0]  m_usb;
         logic [1:0]  e_shift;
         m_mul = m_reg[26:16];
         m_div = m_reg[7:0];
         m_usb = m_reg[29:28];
         e_shift = (m_usb == 2'b00) ? 2'd0 : (m_usb == 2'b01) ? 2'd1 : 2'd2;
         chk("R1 rdata", rdata, m_reg);
         chk("R1 out_range", 32'(out_range), 32'(m_reg[15:14]));
         chk("R2 synth_mult", 32'(synth_mult), (m_mul == 0) ? 32'd0 : 32'(m_mul) + 1);
         chk("R2 pll_active", 32'(pll_active), 32'(m_mul != 0));
         chk("R3 flags", {30'd0, div_hold, div_bypass}, {30'd0, m_div == 0, m_div == 1});
         chk("R3 div_ratio", 32'(div_ratio), 32'(m_div));
         chk("R4 usb_shift", 32'(usb_shift), 32'(e_shift));
         chk("R6 lock", 32'(lock),
             32'(d2_l && (d2_a == m_seq) && m_mul != 0 && m_div != 0));
      end
   end

   task automatic do_write(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] word(input int usb, input int mul, input int rng,
                                        input int cnt, input int dv);
      return (32'(usb) << 28) | (32'(mul) << 16) | (32'(rng) << 14) | (32'(cnt) << 8) | 32'(dv);
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired, actual=running expected=done");
         report();
      end
   end

   initial begin
      idle(3);
      chk("R9 rdata in reset", rdata, 32'd0);
      chk("R9 lock in reset", 32'(lock), 32'd0);
      chk("R9 active in reset", 32'(pll_active), 32'd0);
      rst_n = 1'b1;
      idle(20);

      // count 0, bypass, divide-by-1 post
      do_write(word(0, 5, 1, 0, 1));
      chk("R5 lock after write", 32'(lock), 32'd0);
      idle(70);
      chk("R7 lock with count 0", 32'(lock), 32'd1);
      chk("R2 mult 5", 32'(synth_mult), 32'd6);
      chk("R3 bypass", 32'(div_bypass), 32'd1);

      // long count, max multiplier
      do_write(word(2, 2047, 2, 63, 255));
      chk("R5 lock after rewrite", 32'(lock), 32'd0);
      idle(300);
      chk("R6 lock before expiry", 32'(lock), 32'd0);
      idle(600);
      chk("R6 lock after expiry", 32'(lock), 32'd1);
      chk("R2 mult max", 32'(synth_mult), 32'd2048);
      chk("R4 divide by 4", 32'(usb_shift), 32'd2);

      // restart during a countdown
      do_write(word(1, 9, 0, 40, 7));
      idle(100);
      do_write(word(1, 9, 0, 2, 7));
      idle(120);
      chk("R6 restart lock", 32'(lock), 32'd1);
      chk("R4 divide by 2", 32'(usb_shift), 32'd1);

      // multiplier zero gates lock
      do_write(word(0, 0, 0, 0, 3));
      idle(120);
      chk("R8 lock with mul 0", 32'(lock), 32'd0);
      chk("R2 mult off", 32'(synth_mult), 32'd0);

      // divider zero gates lock
      do_write(word(0, 3, 3, 1, 0));
      idle(120);
      chk("R8 lock with div 0", 32'(lock), 32'd0);
      chk("R3 hold", 32'(div_hold), 32'd1);

      // all ones: reserved post code and unused bits
      do_write(32'hFFFF_FFFF);
      chk("R10 unused bits", rdata, 32'h37FF_FFFF);
      chk("R4 reserved readback", 32'(rdata[29:28]), 32'd3);
      chk("R4 reserved shift", 32'(usb_shift), 32'd2);
      idle(800);
      chk("R6 lock all ones", 32'(lock), 32'd1);

      // unused bits only
      do_write(32'hC800_0000);
      chk("R10 unused ignored", rdata, 32'd0);
      chk("R1 empty word", 32'(pll_active), 32'd0);
      idle(60);

      do_write(word(0, 1, 1, 3, 2));
      idle(100);
      chk("R4 divide by 1", 32'(usb_shift), 32'd0);
      chk("R1 range", 32'(out_range), 32'd1);
      chk("R6 lock count 3", 32'(lock), 32'd1);

      finished = 1'b1;
      report();
   end
endmodule